// File: doc/BRIEF.md
# Configuration Data Source Sequencer

This block sits on the memory side of a byte-wide passive configuration load. At power-up it pulls a shared open-drain enable line low for a power-on delay. A strap input chooses between a long and a short delay. When the delay ends it lets go of the line instead of driving it high. The line is wired to the target's status pin, so it only reads high once the target has also left reset.

After the line is sensed high, the block reads bytes from a local memory in address order and drives them on an 8-bit bus. It also produces the data clock from an internal divider of its own clock. Each byte is put on the bus at a falling edge of the data clock and held until the next falling edge.

If the shared line drops during a transfer, the block stops the clock, releases the bus and rewinds to address zero. When the line rises again it starts over. After the last byte, the data clock stays low and the bus is released.

Top module: `cfg_stream_src`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `oe_pull_low` is 1, `cfg_clk` is 0, `cfg_data_oe` is 0 and `mem_addr` is 0.
- R2: While `pwr_good` is low the delay counter holds at zero and `oe_pull_low` is 1 one cycle later. If `pwr_good` falls during a transfer, `cfg_clk` and `cfg_data_oe` are 0 within two cycles.
- R3: `dly_sel` is captured while `pwr_good` is low: 0 selects `LONG_CYC` and 1 selects `SHORT_CYC`. `oe_pull_low` goes to 0 exactly that many rising clock edges after `pwr_good` is first high. Changes to `dly_sel` after that point are ignored.
- R4: `oe_pull_low` is a pull-down enable only (1 = drive line low, 0 = release). While it is held at 1, `cfg_data_oe` stays 0, whatever `line_sense` does.
- R5: After the delay, no transfer starts while `line_sense` is low: `cfg_clk` and `cfg_data_oe` stay 0. `line_sense` passes through a `SYNC_STAGES`-flop synchronizer.
- R6: During a transfer `cfg_clk` is low for exactly `DCLK_HALF` cycles and high for exactly `DCLK_HALF` cycles (`DCLK_HALF` >= 2).
- R7: Bytes appear in address order 0 to `NUM_BYTES`-1, one per rising edge of `cfg_clk`. The byte for address a is the `mem_rdata` returned one cycle after `mem_addr` equals a.
- R8: Each byte is driven at a falling edge of `cfg_clk`, or at transfer start with `cfg_clk` low. It is stable through the next rising edge and held until the following falling edge.
- R9: If the synchronized line reads low during a transfer, the next clock sets `cfg_clk`=0, `cfg_data_oe`=0 and `mem_addr`=0. That is `SYNC_STAGES`+1 cycles after `line_sense` falls. When the line is high again, the transfer restarts from address 0.
- R10: After the falling edge that follows the last byte's rising edge, `cfg_clk` stays 0 and `cfg_data_oe` stays 0 until `rst` or `pwr_good` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supplies valid; low holds the block in its power-on state |
| dly_sel | input | 1 | Delay strap: 0 long, 1 short |
| line_sense | input | 1 | Sensed level of the shared enable/status line |
| oe_pull_low | output | 1 | 1 pulls the shared line low, 0 releases it |
| mem_addr | output | ADDR_W | Byte address to the local memory |
| mem_rdata | input | 8 | Memory read data, one cycle after address |
| cfg_data | output | 8 | Configuration byte bus |
| cfg_data_oe | output | 1 | Byte bus drive enable (0 = tri-stated) |
| cfg_clk | output | 1 | Generated data clock |

## Verification
The hardest case to reach from the ports is the shared line dropping in the middle of a transfer at an arbitrary byte, followed by a clean restart from address zero. The bench counts rising data-clock edges and pulls the line low after a randomly chosen number of bytes. It then holds the line low for a random interval and releases it. It checks that the first byte after the restart is byte zero again and that the timing of each clock phase is unchanged. A loss of power-good during a transfer and a strap change just after the delay starts are also driven on purpose, so the reset paths and the capture of the strap are exercised.

// File: rtl/cfg_src_pkg.sv
package cfg_src_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } seq_st_e;
endpackage

// File: rtl/cfg_por_timer.sv
module cfg_por_timer #(
  parameter int LONG_CYC  = 5_000_000,
  parameter int SHORT_CYC = 100_000
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic dly_sel,
  output logic por_done
);
  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW   = $clog2(MAXC + 1) + 1;
  localparam logic [CW-1:0] LIM_LONG  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] LIM_SHORT = CW'(SHORT_CYC - 1);

  logic [CW-1:0] cnt;
  logic          sel_short;
  logic [CW-1:0] limit;

  assign limit = sel_short ? LIM_SHORT : LIM_LONG;

  always_ff @(posedge clk) begin
    if (rst || !pwr_good) begin
      cnt       <= '0;
      por_done  <= 1'b0;
      sel_short <= dly_sel;
    end else if (!por_done) begin
      if (cnt == limit) por_done <= 1'b1;
      else              cnt      <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_one
      logic r;
      always_ff @(posedge clk) begin
        if (rst) r <= 1'b0;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
      end
      assign q = sr[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cfg_dclk_div.sv
module cfg_dclk_div #(
  parameter int HALF = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PW-1:0] LAST_PH = PW'(HALF - 1);

  logic [PW-1:0] phase;

  assign tick = en && (phase == LAST_PH);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) phase <= '0;
    else                    phase <= phase + PW'(1);
  end
endmodule

// File: rtl/cfg_byte_seq.sv
module cfg_byte_seq
  import cfg_src_pkg::*;
#(
  parameter int NUM_BYTES = 64,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_done,
  input  logic              line_hi,
  input  logic              tick,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        cfg_data,
  output logic              cfg_data_oe,
  output logic              cfg_clk,
  output logic              div_en
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(NUM_BYTES - 1);

  seq_st_e st;
  logic    fin;

  assign div_en = (st == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst || !por_done) begin
      st          <= ST_OFF;
      mem_addr    <= '0;
      cfg_data    <= '0;
      cfg_data_oe <= 1'b0;
      cfg_clk     <= 1'b0;
      fin         <= 1'b0;
    end else begin
      unique case (st)
        ST_OFF: st <= ST_WAIT;
        ST_WAIT: begin
          if (line_hi) begin
            st          <= ST_RUN;
            cfg_data    <= mem_rdata;
            cfg_data_oe <= 1'b1;
          end
        end
        ST_RUN: begin
          if (!line_hi) begin
            st          <= ST_WAIT;
            cfg_clk     <= 1'b0;
            cfg_data_oe <= 1'b0;
            mem_addr    <= '0;
            fin         <= 1'b0;
          end else if (tick) begin
            if (!cfg_clk) begin
              cfg_clk <= 1'b1;
              if (mem_addr == LAST_A) fin      <= 1'b1;
              else                    mem_addr <= mem_addr + ADDR_W'(1);
            end else begin
              cfg_clk <= 1'b0;
              if (fin) begin
                st          <= ST_DONE;
                cfg_data_oe <= 1'b0;
              end else begin
                cfg_data <= mem_rdata;
              end
            end
          end
        end
        ST_DONE: st <= ST_DONE;
        default: st <= ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/cfg_stream_src.sv
module cfg_stream_src #(
  parameter int LONG_CYC    = 5_000_000,
  parameter int SHORT_CYC   = 100_000,
  parameter int DCLK_HALF   = 3,
  parameter int NUM_BYTES   = 64,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good,
  input  logic              dly_sel,
  input  logic              line_sense,
  output logic              oe_pull_low,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        cfg_data,
  output logic              cfg_data_oe,
  output logic              cfg_clk
);
  logic por_done;
  logic line_hi;
  logic tick;
  logic div_en;

  cfg_por_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_por (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .dly_sel(dly_sel), .por_done(por_done)
  );

  assign oe_pull_low = ~por_done;

  cfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(line_sense), .q(line_hi)
  );

  cfg_dclk_div #(.HALF(DCLK_HALF)) u_div (
    .clk(clk), .rst(rst), .en(div_en), .tick(tick)
  );

  cfg_byte_seq #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .por_done(por_done), .line_hi(line_hi), .tick(tick),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .cfg_data(cfg_data),
    .cfg_data_oe(cfg_data_oe), .cfg_clk(cfg_clk), .div_en(div_en)
  );
endmodule

// File: rtl/cfg_src_chk.sv
module cfg_src_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_good,
  input logic       line_pd,
  input logic       line_hi,
  input logic [7:0] dat,
  input logic       dat_oe,
  input logic       dclk
);
  AST_PWR_LOW_PULLS: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> line_pd);                                  // R2
  AST_NO_DATA_IN_DELAY: assert property (@(posedge clk) disable iff (rst)
    (line_pd && $past(line_pd)) |-> !dat_oe);                // R4
  AST_LINE_LOW_STOPS_CLK: assert property (@(posedge clk) disable iff (rst)
    !line_hi |=> !dclk);                                     // R9
  AST_RISE_ONLY_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    $rose(dclk) |-> dat_oe);                                 // R7
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    dclk |-> $stable(dat));                                  // R8
endmodule

bind cfg_stream_src cfg_src_chk u_chk (
  .clk(clk), .rst(rst), .pwr_good(pwr_good), .line_pd(oe_pull_low),
  .line_hi(line_hi), .dat(cfg_data), .dat_oe(cfg_data_oe), .dclk(cfg_clk)
);

// File: tb/tb_cfg_stream_src.sv
module tb_cfg_stream_src;
  localparam int CLK_PERIOD = 10;
  localparam int LONG_C  = 400;
  localparam int SHORT_C = 40;
  localparam int HALF    = 3;
  localparam int NB      = 24;
  localparam int SYNC    = 2;
  localparam int AW      = $clog2(NB);

  logic clk = 1'b0;
  logic rst, pwr_good, dly_sel, line_sense;
  logic oe_pull_low, cfg_data_oe, cfg_clk;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata, cfg_data;
  logic [7:0] img [NB];

  int checks = 0, fails = 0;
  int completes = 0, rises = 0, idx = 0, lo_len = 0, hi_len = 0;
  bit aborting = 0, ended = 0;
  logic p_clk = 0, p_oe = 0;
  logic [7:0] p_dat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_stream_src #(.LONG_CYC(LONG_C), .SHORT_CYC(SHORT_C), .DCLK_HALF(HALF),
                   .NUM_BYTES(NB), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .dly_sel(dly_sel),
    .line_sense(line_sense), .oe_pull_low(oe_pull_low), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .cfg_data(cfg_data), .cfg_data_oe(cfg_data_oe),
    .cfg_clk(cfg_clk)
  );

  always @(posedge clk) mem_rdata <= img[mem_addr];

  function automatic int exp_delay(input bit sel);
    return sel ? SHORT_C : LONG_C;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // stream monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (cfg_data_oe && !p_oe) begin
        idx = 0; lo_len = 1; aborting = 0;
      end else if (cfg_clk && !p_clk) begin
        chk(lo_len == HALF, "R6 low phase", lo_len, HALF);
        chk(cfg_data_oe && cfg_data == p_dat, "R8 setup stable", cfg_data, p_dat);
        if (idx < NB) chk(cfg_data == img[idx], "R7 byte order", cfg_data, img[idx]);
        else          chk(0, "R7 extra byte", idx, NB);
        idx++; rises++; hi_len = 1;
      end else if (cfg_clk) begin
        hi_len++;
        if (cfg_data != p_dat) chk(0, "R8 hold while high", cfg_data, p_dat);
      end else if (p_clk) begin
        if (!aborting) chk(hi_len == HALF, "R6 high phase", hi_len, HALF);
        lo_len = 1;
      end else if (cfg_data_oe) lo_len++;
      if (p_oe && !cfg_data_oe && !aborting) begin
        chk(idx == NB && !cfg_clk, "R10 end after last byte", idx, NB);
        completes++;
      end
      p_clk = cfg_clk; p_oe = cfg_data_oe; p_dat = cfg_data;
    end
  end

  task automatic measure(input bit sel, output int n, output bit bad);
    @(negedge clk); pwr_good = 0; dly_sel = sel;
    @(negedge clk); pwr_good = 1;
    @(negedge clk); dly_sel = ~sel;   // strap change after capture: ignored
    n = 1; bad = 0;
    while (oe_pull_low && n < LONG_C + 20) begin
      if (cfg_data_oe || cfg_clk) bad = 1;
      @(negedge clk); n++;
    end
  endtask

  task automatic wait_done(input int prev, input string req);
    int t = 0;
    while (completes == prev && t < 20000) begin @(negedge clk); t++; end
    chk(completes == prev + 1, req, completes, prev + 1);
  endtask

  task automatic quiet(input int cyc, input string req);
    bit bad = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (cfg_clk || cfg_data_oe) bad = 1;
    end
    chk(!bad, req, bad, 0);
  endtask

  task automatic do_abort(input int after_bytes, input int hold);
    int r0 = rises;
    int t = 0;
    while (rises < r0 + after_bytes && t < 5000) begin @(negedge clk); t++; end
    aborting = 1; line_sense = 0;
    repeat (SYNC + 1) @(negedge clk);
    chk(!cfg_clk && !cfg_data_oe && mem_addr == 0, "R9 stop and rewind",
        {cfg_clk, cfg_data_oe, 6'(mem_addr)}, 0);
    quiet(hold, "R9 stays idle while line low");
    line_sense = 1;
  endtask

  initial begin
    int n; bit bad; int c0;
    void'($urandom(32'd7719));
    for (int i = 0; i < NB; i++) img[i] = 8'($urandom);
    rst = 1; pwr_good = 0; dly_sel = 0; line_sense = 0;
    repeat (4) @(negedge clk);
    chk(oe_pull_low && !cfg_clk && !cfg_data_oe && mem_addr == 0, "R1 reset state",
        {oe_pull_low, cfg_clk, cfg_data_oe}, 3'b100);
    rst = 0;
    @(negedge clk);
    chk(oe_pull_low && !cfg_data_oe, "R1 after reset", oe_pull_low, 1);

    // long delay, target holding line low
    measure(0, n, bad);
    chk(n == exp_delay(0), "R3 long delay", n, exp_delay(0));
    chk(!bad, "R4 silent during delay", bad, 0);
    quiet(40, "R5 no start while line low");
    c0 = completes; line_sense = 1;
    wait_done(c0, "R7 full transfer");
    quiet(30, "R10 clock parked after end");

    // short delay, line already high during delay
    measure(1, n, bad);
    chk(n == exp_delay(1), "R3 short delay", n, exp_delay(1));
    chk(!bad, "R4 line high ignored during delay", bad, 0);
    wait_done(completes, "R7 transfer after short delay");

    // directed abort near start and near end
    line_sense = 0; measure(1, n, bad); line_sense = 1;
    c0 = completes; do_abort(1, 5);
    wait_done(c0, "R9 restart from zero completes");
    line_sense = 0; measure(1, n, bad); line_sense = 1;
    c0 = completes; do_abort(NB - 1, 9);
    wait_done(c0, "R9 late abort restart");

    // power-good loss during transfer
    line_sense = 0; measure(1, n, bad); line_sense = 1;
    repeat (HALF * 8) @(negedge clk);
    aborting = 1; pwr_good = 0;
    @(negedge clk);
    chk(oe_pull_low, "R2 pull low on power loss", oe_pull_low, 1);
    @(negedge clk);
    chk(!cfg_clk && !cfg_data_oe, "R2 transfer stops on power loss",
        {cfg_clk, cfg_data_oe}, 0);

    // random mix
    for (int it = 0; it < 8; it++) begin
      bit sel = 1'($urandom);
      bit ab  = 1'($urandom);
      line_sense = 0; measure(sel, n, bad);
      chk(n == exp_delay(sel), "R3 random delay", n, exp_delay(sel));
      repeat ($urandom_range(1, 15)) @(negedge clk);
      line_sense = 1; c0 = completes;
      if (ab) do_abort($urandom_range(1, NB - 2), $urandom_range(3, 20));
      wait_done(c0, "R7 random transfer");
    end

    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule